// File: doc/BRIEF.md
# SMBus Slave Front End

This block is the serial side of a small register-mapped peripheral. It watches a two-wire bus through a synchronizer and sees start, repeated start and stop conditions. It matches a 7-bit slave address. The upper four bits of that address are a parameter and the lower three come from strap inputs, so eight copies can share one bus. After an address match it performs register writes and reads. The first byte of a write is a command byte that sets a register pointer. A later read returns the register that the pointer selects. The block drives acknowledge bits and read data through an open-drain data output, and the clock line is input only.

Two bus-management functions sit on top of a plain two-wire slave. While the core raises its alert request, the block answers a read to the alert response address 0001100. It returns its own address and tells the core that the alert has been taken. A counter measures how long the clock has been low. When the low time reaches a set number of system clock cycles, the block drops any transfer and waits for the next start. The core behind the block sees a simple register port: a register index, a one-cycle write strobe with its data, and a read-data input for the selected register.

Top module: `smb_slave_fe`

## Requirements
- R1: After reset the data output is released (sda_oe = 0), reg_wr_en and alert_clr are low and the register pointer is 0.
- R2: An address byte whose upper seven bits equal {ADDR_HI, strap_addr} is acknowledged: sda_oe is 1 for the ninth clock of that byte. Bit 0 of the address byte selects the direction (1 = read, 0 = write).
- R3: An address byte that matches neither the slave address nor an alert response is not acknowledged. The block then does not drive the data line and makes no register write until the next start.
- R4: In a write, the first byte after the address is the command. A value below NUM_REGS is acknowledged and becomes the register pointer. A value of NUM_REGS or more is not acknowledged, leaves the pointer unchanged, and the rest of the transfer is ignored.
- R5: Each further byte of a write is acknowledged and issued as a one-cycle reg_wr_en pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R6: In a read, the register at the pointer is sent most significant bit first, and sda_oe is 1 only for 0 bits. The line is released for the master's acknowledge bit. If the master acknowledges, the same register is sent again; if not, the block stays off the bus until the next start or stop.
- R7: A repeated start restarts address matching and keeps the register pointer. A read with no command byte returns the register last selected.
- R8: A read addressed to 0001100 while alert_req is 1 is acknowledged and returns the byte {ADDR_HI, strap_addr, 0}. alert_clr pulses for exactly one cycle. While alert_req is 0, that address is not acknowledged.
- R9: When the clock has been low for TIMEOUT_CYC consecutive system clock cycles, the block releases the data line and returns to idle. It ignores the bus until the next start. Shorter low periods have no effect on a transfer.
- R10: A stop in the middle of a byte returns the block to idle with the data line released, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_addr | input | 3 | Lower three bits of the slave address |
| alert_req | input | 1 | Core requests service; enables the alert response reply |
| alert_clr | output | 1 | One-cycle pulse when the alert response is acknowledged |
| reg_addr | output | $clog2(NUM_REGS) | Register pointer |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data of the register at reg_addr |

## Verification
Write-then-read pairs to random registers with random data and random strap values show that data goes to the right register and comes back on the right bit lanes. The directed values 00 and FF show that the line is driven only for zero bits. Addresses with a wrong strap part and with a wrong fixed part, out-of-range commands, and alert reads with and without a request each tell acceptance apart from refusal, and every refusal is followed by a check for writes that should not happen. Clock-low stretches below and above the timeout tell a tolerated stretch from an abandoned transfer. A stop in the middle of a byte, followed by a read with no command byte, shows that the pointer outlives both stops and repeated starts.

// File: rtl/smb_fe_pkg.sv
package smb_fe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK_SET, ST_ACK_HOLD, ST_TX, ST_TX_MACK, ST_SKIP
    } fe_state_e;

    typedef enum logic [1:0] { PH_ADDR, PH_CMD, PH_DATA } rx_phase_e;

    typedef enum logic [1:0] { AFT_CMD, AFT_DATA, AFT_READ, AFT_ARA } after_ack_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_in,
    output logic [NLINES-1:0] line_s,
    output logic [NLINES-1:0] line_p
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= line_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign line_s[g] = sync_q;
        assign line_p[g] = prev_q;
    end
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
    parameter int LIMIT = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_low,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit_d, hit_q;

    always_comb begin
        cnt_d = cnt_q;
        hit_d = 1'b0;
        if (!line_low) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_d = cnt_q + CW'(1);
            hit_d = (cnt_q == CW'(LIMIT - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            hit_q <= hit_d;
        end
    end

    assign expired = hit_q;
endmodule

// File: rtl/smb_slave_fe.sv
module smb_slave_fe
    import smb_fe_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0100,
    parameter int         NUM_REGS    = 7,
    parameter int         TIMEOUT_CYC = 2_500_000,
    parameter logic [6:0] ARA_ADDR    = 7'b0001100,
    localparam int        PW          = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic [2:0]    strap_addr,
    input  logic          alert_req,
    output logic          alert_clr,
    output logic [PW-1:0] reg_addr,
    output logic          reg_wr_en,
    output logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_rdata
);
    typedef struct packed {
        fe_state_e  st;
        rx_phase_e  ph;
        after_ack_e aft;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic [PW-1:0] ptr;
        logic       oe;
        logic       mack;
        logic       wr;
        logic [7:0] wdata;
        logic       aclr;
    } fe_t;

    logic [1:0] ln_s, ln_p;
    logic       tmo;

    smb_line_sync #(.NLINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .line_in({sda_in, scl_in}), .line_s(ln_s), .line_p(ln_p)
    );

    smb_low_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .line_low(~ln_s[0]), .expired(tmo)
    );

    logic scl_s, scl_p, sda_s, sda_p;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    assign scl_s = ln_s[0];
    assign scl_p = ln_p[0];
    assign sda_s = ln_s[1];
    assign sda_p = ln_p[1];
    assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
    assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
    assign ev_rise  = scl_s & ~scl_p;
    assign ev_fall  = ~scl_s & scl_p;

    fe_t        r_d, r_q;
    logic [6:0] own_addr;
    logic [7:0] rx_byte, tx_byte;

    assign own_addr = {ADDR_HI, strap_addr};
    assign rx_byte  = {r_q.sh[6:0], sda_s};
    assign tx_byte  = (r_q.aft == AFT_ARA) ? {own_addr, 1'b0} : reg_rdata;

    always_comb begin
        r_d      = r_q;
        r_d.wr   = 1'b0;
        r_d.aclr = 1'b0;
        if (tmo) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (ev_start) begin
            r_d.st  = ST_RX;
            r_d.ph  = PH_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (ev_stop) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RX: if (ev_rise) begin
                    r_d.sh  = rx_byte;
                    r_d.cnt = r_q.cnt + 3'd1;
                    if (r_q.cnt == 3'd7) begin
                        r_d.st = ST_SKIP;
                        unique case (r_q.ph)
                            PH_ADDR: begin
                                if (rx_byte[7:1] == own_addr) begin
                                    r_d.st  = ST_ACK_SET;
                                    r_d.aft = rx_byte[0] ? AFT_READ : AFT_CMD;
                                end else if (rx_byte[7:1] == ARA_ADDR && rx_byte[0] && alert_req) begin
                                    r_d.st   = ST_ACK_SET;
                                    r_d.aft  = AFT_ARA;
                                    r_d.aclr = 1'b1;
                                end
                            end
                            PH_CMD: begin
                                if (rx_byte < 8'(NUM_REGS)) begin
                                    r_d.ptr = rx_byte[PW-1:0];
                                    r_d.st  = ST_ACK_SET;
                                    r_d.aft = AFT_DATA;
                                end
                            end
                            default: begin
                                r_d.wr    = 1'b1;
                                r_d.wdata = rx_byte;
                                r_d.st    = ST_ACK_SET;
                                r_d.aft   = AFT_DATA;
                            end
                        endcase
                    end
                end
                ST_ACK_SET: if (ev_fall) begin
                    r_d.oe = 1'b1;
                    r_d.st = ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (ev_fall) begin
                    r_d.cnt = '0;
                    unique case (r_q.aft)
                        AFT_CMD: begin
                            r_d.st = ST_RX;
                            r_d.ph = PH_CMD;
                            r_d.oe = 1'b0;
                        end
                        AFT_DATA: begin
                            r_d.st = ST_RX;
                            r_d.ph = PH_DATA;
                            r_d.oe = 1'b0;
                        end
                        default: begin
                            r_d.st = ST_TX;
                            r_d.sh = tx_byte;
                            r_d.oe = ~tx_byte[7];
                        end
                    endcase
                end
                ST_TX: if (ev_fall) begin
                    if (r_q.cnt == 3'd7) begin
                        r_d.oe  = 1'b0;
                        r_d.st  = ST_TX_MACK;
                        r_d.cnt = '0;
                    end else begin
                        r_d.sh  = {r_q.sh[6:0], 1'b0};
                        r_d.oe  = ~r_q.sh[6];
                        r_d.cnt = r_q.cnt + 3'd1;
                    end
                end
                ST_TX_MACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (ev_fall) begin
                        if (r_q.mack) begin
                            r_d.st = ST_TX;
                            r_d.sh = tx_byte;
                            r_d.oe = ~tx_byte[7];
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe    = r_q.oe;
    assign alert_clr = r_q.aclr;
    assign reg_addr  = r_q.ptr;
    assign reg_wr_en = r_q.wr;
    assign reg_wdata = r_q.wdata;
endmodule

// File: rtl/smb_slave_fe_chk.sv
module smb_slave_fe_chk #(
    parameter int NUM_REGS    = 7,
    parameter int TIMEOUT_CYC = 2_500_000,
    localparam int PW         = $clog2(NUM_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          sda_oe,
    input logic          alert_req,
    input logic          alert_clr,
    input logic          reg_wr_en,
    input logic [PW-1:0] reg_addr
);
    localparam logic [31:0] LOW_LIM = 32'(TIMEOUT_CYC + 8);

    logic [31:0] low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_q <= '0;
        else if (scl_in)         low_q <= '0;
        else if (low_q < LOW_LIM) low_q <= low_q + 32'd1;
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);                                   // R5
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (int'(reg_addr) < NUM_REGS));                  // R4
    AST_ACLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr |=> !alert_clr);                                   // R8
    AST_ACLR_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clr |-> alert_req);                                    // R8
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);                      // R6
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q >= LOW_LIM) |-> !sda_oe);                             // R9
endmodule

bind smb_slave_fe smb_slave_fe_chk #(
    .NUM_REGS(NUM_REGS), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .alert_req(alert_req), .alert_clr(alert_clr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr)
);

// File: tb/smb_slave_fe_tb.sv
module smb_slave_fe_tb;
    localparam int TMO = 300;
    localparam int Q   = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, m_scl, m_sda, sda_bus;
    logic [2:0] strap;
    logic       alert_req;
    logic       sda_oe, reg_wr_en, alert_clr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] mem  [0:7];
    logic [7:0] expm [0:7];
    logic [2:0] exp_ptr;
    int total, bad, aclr_cnt, wr_cnt;
    bit done;

    assign sda_bus   = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_slave_fe #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .strap_addr(strap), .alert_req(alert_req), .alert_clr(alert_clr),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
            aclr_cnt <= 0;
            wr_cnt   <= 0;
        end else begin
            if (reg_wr_en) begin
                mem[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (alert_clr) aclr_cnt <= aclr_cnt + 1;
        end
    end

    function automatic logic [6:0] own(input logic [2:0] s);
        return {4'b0100, s};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~mack);
    endtask

    task automatic reg_write(input logic [2:0] r, input logic [7:0] d, output logic [2:0] acks);
        logic a0, a1, a2;
        b_start();
        send_byte({own(strap), 1'b0}, a0);
        send_byte({5'b0, r}, a1);
        send_byte(d, a2);
        b_stop();
        acks = {a0, a1, a2};
        expm[r] = d;
        exp_ptr = r;
    endtask

    task automatic reg_read(input logic [2:0] r, output logic [7:0] d, output logic [2:0] acks);
        logic a0, a1, a2;
        b_start();
        send_byte({own(strap), 1'b0}, a0);
        send_byte({5'b0, r}, a1);
        b_start();
        send_byte({own(strap), 1'b1}, a2);
        recv_byte(d, 1'b0);
        b_stop();
        acks = {a0, a1, a2};
        exp_ptr = r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d, d2;
        logic a, b;
        int wr0, ac0;
        total = 0; bad = 0; done = 0;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 3'd5; alert_req = 1'b0;
        for (int i = 0; i < 8; i++) expm[i] = 8'h00;
        exp_ptr = 3'd0;
        wq(5); rst_n = 1'b1; wq(3);

        check("R1 sda_oe", sda_oe, 0);
        check("R1 reg_wr_en", reg_wr_en, 0);
        check("R1 alert_clr", alert_clr, 0);
        check("R1 reg_addr", reg_addr, 0);

        // R2 R4 R5 directed write, R6 read back
        reg_write(3'd3, 8'hA5, acks);
        check("R2 R4 R5 write acks", acks, 3'b111);
        check("R5 stored", mem[3], 8'hA5);
        check("R5 one strobe", wr_cnt, 1);
        reg_read(3'd3, d, acks);
        check("R6 read acks", acks, 3'b111);
        check("R6 read data", d, 8'hA5);

        // R6 all-zero / all-one patterns, repeated byte on master ack
        reg_write(3'd0, 8'h00, acks);
        reg_write(3'd6, 8'hFF, acks);
        check("R4 top register acks", acks, 3'b111);
        b_start();
        send_byte({own(strap), 1'b0}, a);
        send_byte(8'd6, a);
        b_start();
        send_byte({own(strap), 1'b1}, a);
        check("R7 read after repeated start acked", a, 1);
        recv_byte(d, 1'b1);
        recv_byte(d2, 1'b0);
        b_stop();
        check("R6 first byte FF", d, 8'hFF);
        check("R6 repeated byte FF", d2, 8'hFF);
        reg_read(3'd0, d, acks);
        check("R6 zero byte", d, 8'h00);

        // R7 read with no command uses kept pointer
        reg_read(3'd3, d, acks);
        b_start();
        send_byte({own(strap), 1'b1}, a);
        recv_byte(d, 1'b0);
        b_stop();
        check("R7 kept pointer", d, expm[exp_ptr]);

        // R4 out-of-range command
        wr0 = wr_cnt;
        b_start();
        send_byte({own(strap), 1'b0}, a);
        send_byte(8'd7, a);
        check("R4 cmd 7 nacked", a, 0);
        send_byte(8'h3C, a);
        check("R4 data after bad cmd ignored", a, 0);
        b_stop();
        check("R4 no write", wr_cnt, wr0);
        b_start();
        send_byte({own(strap), 1'b1}, a);
        recv_byte(d, 1'b0);
        b_stop();
        check("R4 pointer unchanged", d, expm[exp_ptr]);

        // R3 wrong strap and wrong upper bits
        wr0 = wr_cnt;
        b_start();
        send_byte({4'b0100, strap ^ 3'd2, 1'b0}, a);
        check("R3 wrong strap nacked", a, 0);
        send_byte(8'd1, a);
        check("R3 following byte ignored", a, 0);
        b_stop();
        b_start();
        send_byte({4'b0110, strap, 1'b0}, a);
        check("R3 wrong upper bits nacked", a, 0);
        b_stop();
        check("R3 no write", wr_cnt, wr0);

        // R8 alert response
        ac0 = aclr_cnt;
        b_start();
        send_byte({7'b0001100, 1'b1}, a);
        b_stop();
        check("R8 no request nacked", a, 0);
        check("R8 no clear", aclr_cnt, ac0);
        alert_req = 1'b1;
        b_start();
        send_byte({7'b0001100, 1'b0}, a);
        b_stop();
        check("R8 write direction nacked", a, 0);
        b_start();
        send_byte({7'b0001100, 1'b1}, a);
        check("R8 acked", a, 1);
        recv_byte(d, 1'b0);
        b_stop();
        check("R8 own address byte", d, {own(strap), 1'b0});
        check("R8 one clear pulse", aclr_cnt, ac0 + 1);
        alert_req = 1'b0;

        // R9 short stretch tolerated
        b_start();
        for (int i = 7; i >= 0; i--) begin
            send_bit(((own(strap) << 1) >> i) & 1'b1);
            if (i == 4) wq(TMO / 2);
        end
        recv_bit(b);
        b_stop();
        check("R9 short stretch still acked", b, 0);

        // R9 timeout during acknowledge
        b_start();
        for (int i = 7; i >= 0; i--) send_bit(((own(strap) << 1) >> i) & 1'b1);
        wq(TMO - 40);
        check("R9 ack held before limit", sda_oe, 1);
        wq(60);
        check("R9 released after limit", sda_oe, 0);
        wr0 = wr_cnt;
        send_byte({own(strap), 1'b0}, a);
        check("R9 bus ignored after timeout", a, 0);
        send_byte(8'd2, a);
        b_stop();
        check("R9 no write after timeout", wr_cnt, wr0);

        // R10 stop mid byte
        b_start();
        send_byte({own(strap), 1'b0}, a);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        b_stop();
        check("R10 released", sda_oe, 0);
        b_start();
        send_byte({own(strap), 1'b1}, a);
        check("R10 next transfer acked", a, 1);
        recv_byte(d, 1'b0);
        b_stop();
        check("R10 pointer kept", d, expm[exp_ptr]);

        // random write/read pairs
        for (int k = 0; k < 24; k++) begin
            logic [2:0] rr, rw;
            logic [7:0] dv;
            strap = 3'($urandom);
            rw = 3'($urandom % 7);
            dv = 8'($urandom);
            reg_write(rw, dv, acks);
            check("R2 R5 random write acks", acks, 3'b111);
            rr = 3'($urandom % 7);
            reg_read(rr, d, acks);
            check("R6 random read", d, expm[rr]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule